// File: doc/BRIEF.md
# Write-Through Data Cache with Address-Space Tags

This block sits between a 32-bit CPU data port and external memory. It holds 256 bytes of recently used data, arranged as 16 direct-mapped lines of four longwords. All accesses are full longwords.

Each line stores the upper address bits and a 3-bit address-space code. A lookup hits only when both the address and the space code match, and the addressed longword is valid. Read hits complete in the same cycle with no memory traffic. Read misses fetch one longword and fill it. Every write is passed to memory. The cached copy is updated on a write hit. A write miss fills the cache only when allocation on writes is selected.

Five controls set the cache's behaviour: enable, freeze, write-allocate, invalidate-all and invalidate-one-longword. Freeze fixes which addresses are held, but write hits still refresh the held data. The CPU side holds its request stable until `cpu_ready`. The memory side holds `mem_req` until `mem_ready`.

Top module: `wt_dcache`

## Requirements
- R1: The line index is address bits 7:4, the longword within the line is bits 3:2, and the tag is bits 31:8. Two addresses that differ only in bits 31:8 evict each other.
- R2: A cacheable read miss completes with one memory read and returns the memory data. A later read of the same address and space completes with no memory access and returns the same data.
- R3: Every write completes through exactly one memory write, whether it hits or misses, and carries the CPU's address, space and data.
- R4: A write hit replaces the cached longword, so a following read hit returns the new value. This also holds while freeze is set.
- R5: A write miss leaves the cache unchanged when write-allocate is clear. When write-allocate is set and freeze is clear, the written longword is filled and a following read hits with the written value.
- R6: The space code is part of the tag. An access to a cached address with a different space code misses. A write in a different space does not modify the entry held for the original space.
- R7: Requests with space code 3'b111 always go to memory and are never filled into the cache.
- R8: While freeze is set, read misses and write misses fill nothing, and existing entries are never replaced.
- R9: While enable is clear, every access goes to memory and the stored contents are neither read nor modified. After re-enabling, the earlier entries hit with their earlier data.
- R10: A one-cycle pulse on `inv_all` invalidates every longword.
- R11: A pulse on `inv_one` invalidates only the longword selected by bits 7:2 of `inv_addr`. The other longwords of that line stay valid.
- R12: Filling a line under a new tag or space code invalidates the line's other longwords.
- R13: `mem_req` stays high until `mem_ready`, and `cpu_ready` is raised only while `cpu_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all valid bits |
| cfg_enable | input | 1 | Cache enable |
| cfg_freeze | input | 1 | Freeze: no allocation or replacement |
| cfg_wralloc | input | 1 | Fill on write miss |
| inv_all | input | 1 | Invalidate every longword |
| inv_one | input | 1 | Invalidate the longword at inv_addr |
| inv_addr | input | 32 | Address for inv_one |
| cpu_req | input | 1 | CPU request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Longword-aligned byte address |
| cpu_space | input | 3 | Address-space code |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Request complete |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Memory address |
| mem_space | output | 3 | Memory space code |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory done |
| mem_rdata | input | 32 | Memory read data |

## Verification
The bench uses the default geometry: 16 lines of four longwords with a 24-bit tag. At this size, a one-kilobyte stride gives same-index conflicts, and addresses that differ only in bits 3:2 share a line. Together these cover eviction, whole-line invalidation on a new tag, and single-longword clearing. Memory answers after a two-cycle wait, so the stall path is exercised. A hit is recognised by the absence of any memory handshake during the access.

// File: rtl/wt_dcache.sv
module wt_dcache #(
  parameter int LINES = 16,
  parameter int WORDS = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [2:0] BYPASS_SPACE = 3'b111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_freeze,
  input  logic              cfg_wralloc,
  input  logic              inv_all,
  input  logic              inv_one,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [2:0]        cpu_space,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [2:0]        mem_space,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IB = $clog2(LINES);
  localparam int WB = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - 2 - WB - IB;

  logic [TAG_W-1:0]  tag_q [LINES];
  logic [2:0]        spc_q [LINES];
  logic [WORDS-1:0]  val_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES*WORDS];
  logic              busy_q;

  logic [IB-1:0]    idx, iidx;
  logic [WB-1:0]    wsel, iw;
  logic [TAG_W-1:0] tag;
  logic [WORDS-1:0] wbit;
  logic             cacheable, line_match, hit, done, wr_upd, alloc;

  assign idx  = cpu_addr[2+WB +: IB];
  assign wsel = cpu_addr[2 +: WB];
  assign tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  assign iidx = inv_addr[2+WB +: IB];
  assign iw   = inv_addr[2 +: WB];
  assign wbit = {{(WORDS-1){1'b0}}, 1'b1} << wsel;

  assign cacheable  = cfg_enable && (cpu_space != BYPASS_SPACE);
  assign line_match = (tag_q[idx] == tag) && (spc_q[idx] == cpu_space);
  assign hit        = cacheable && line_match && val_q[idx][wsel];

  assign done   = busy_q && mem_ready;
  assign wr_upd = done && cpu_we && hit;
  assign alloc  = done && cacheable && !hit && !cfg_freeze && (!cpu_we || cfg_wralloc);

  assign cpu_ready = busy_q ? mem_ready : (cpu_req && !cpu_we && hit);
  assign cpu_rdata = busy_q ? mem_rdata : dat_q[{idx, wsel}];

  assign mem_req   = busy_q;
  assign mem_we    = cpu_we;
  assign mem_addr  = cpu_addr;
  assign mem_space = cpu_space;
  assign mem_wdata = cpu_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      for (int i = 0; i < LINES; i++) val_q[i] <= '0;
    end else begin
      if (!busy_q && cpu_req && !(!cpu_we && hit)) busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;
      if (alloc) val_q[idx] <= line_match ? (val_q[idx] | wbit) : wbit;
      if (inv_one) val_q[iidx][iw] <= 1'b0;
      if (inv_all)
        for (int i = 0; i < LINES; i++) val_q[i] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      tag_q[idx] <= tag;
      spc_q[idx] <= cpu_space;
    end
    if (alloc || wr_upd)
      dat_q[{idx, wsel}] <= cpu_we ? cpu_wdata : mem_rdata;
  end
endmodule

// File: rtl/wt_dcache_chk.sv
module wt_dcache_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_enable,
  input logic       cpu_req,
  input logic       cpu_we,
  input logic [2:0] cpu_space,
  input logic       cpu_ready,
  input logic       mem_req,
  input logic       mem_we,
  input logic       mem_ready
);
  a_r3_write_goes_out: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_we && cpu_ready |-> mem_req && mem_we && mem_ready);
  a_r2_local_only_reads: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && !mem_req |-> !cpu_we);
  a_r7_bypass_space: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_space == 3'b111 |-> mem_req && mem_ready);
  a_r9_disabled_to_mem: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && !cfg_enable |-> mem_req && mem_ready);
  a_r13_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req);
  a_r13_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);
endmodule

bind wt_dcache wt_dcache_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cpu_req(cpu_req),
  .cpu_we(cpu_we), .cpu_space(cpu_space), .cpu_ready(cpu_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready)
);

// File: tb/wt_dcache_test.sv
module wt_dcache_test;
  logic clk = 0, rst_n = 0;
  logic cfg_enable = 0, cfg_freeze = 0, cfg_wralloc = 0, inv_all = 0, inv_one = 0;
  logic [31:0] inv_addr = '0;
  logic cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [2:0] cpu_space = '0;
  logic cpu_ready, mem_req, mem_we, mem_ready = 0;
  logic [31:0] cpu_rdata, mem_addr, mem_wdata, mem_rdata;
  logic [2:0] mem_space;
  logic [31:0] mem_m [1024];
  int wait_cnt = 0, checks = 0, fails = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  wt_dcache uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_freeze(cfg_freeze),
    .cfg_wralloc(cfg_wralloc), .inv_all(inv_all), .inv_one(inv_one), .inv_addr(inv_addr),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_space(cpu_space),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_space(mem_space),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem_m[mem_addr[11:2]];

  always @(negedge clk) begin
    if (mem_ready) mem_ready = 0;
    else if (mem_req) begin
      if (wait_cnt == 1) begin mem_ready = 1; wait_cnt = 0; end
      else wait_cnt++;
    end
  end

  always @(posedge clk)
    if (mem_req && mem_we && mem_ready) mem_m[mem_addr[11:2]] <= mem_wdata;

  function automatic logic [31:0] init_val(input int a);
    return 32'hC0DE_0000 | 32'(a);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [2:0] sp,
                        input logic [31:0] wd, output logic [31:0] rd, output int nmem);
    bit bad = 0;
    @(negedge clk);
    cpu_we = we; cpu_addr = a; cpu_space = sp; cpu_wdata = wd; cpu_req = 1;
    nmem = 0; rd = '0;
    for (int i = 0; i < 50; i++) begin
      #2;
      if (mem_req && (mem_addr !== a || mem_we !== we || mem_space !== sp || (we && mem_wdata !== wd))) bad = 1;
      if (mem_req && mem_ready) nmem++;
      if (cpu_ready) begin rd = cpu_rdata; break; end
      @(negedge clk);
    end
    if (bad) begin
      fails++;
      $display("FAIL R13 memory fields differ from request at %h", a);
    end
    @(posedge clk); #1 cpu_req = 0;
  endtask

  task automatic pulse_all();
    @(negedge clk); inv_all = 1; @(negedge clk); inv_all = 0;
  endtask

  task automatic test_reset();
    #1;
    chk("R13 reset cpu_ready", 32'(cpu_ready), 0);
    chk("R13 reset mem_req", 32'(mem_req), 0);
  endtask

  task automatic test_read_fill();
    logic [31:0] d; int n;
    access(0, 32'h040, 3'd1, 0, d, n);
    chk("R2 miss mem reads", n, 1); chk("R2 miss data", d, init_val(16));
    access(0, 32'h040, 3'd1, 0, d, n);
    chk("R2 hit mem reads", n, 0); chk("R2 hit data", d, init_val(16));
  endtask

  task automatic test_write_hit();
    logic [31:0] d; int n;
    access(1, 32'h040, 3'd1, 32'h1111_2222, d, n);
    chk("R3 write hit goes out", n, 1); chk("R3 memory updated", mem_m[16], 32'h1111_2222);
    access(0, 32'h040, 3'd1, 0, d, n);
    chk("R4 read after write hit", n, 0); chk("R4 updated data", d, 32'h1111_2222);
    cfg_freeze = 1;
    access(1, 32'h040, 3'd1, 32'h3333_4444, d, n);
    chk("R3 frozen write goes out", n, 1);
    access(0, 32'h040, 3'd1, 0, d, n);
    chk("R4 frozen hit", n, 0); chk("R4 frozen updated data", d, 32'h3333_4444);
    cfg_freeze = 0;
  endtask

  task automatic test_write_alloc();
    logic [31:0] d; int n;
    cfg_wralloc = 0;
    access(1, 32'h080, 3'd1, 32'h5555_0001, d, n);
    chk("R3 write miss goes out", n, 1);
    access(0, 32'h080, 3'd1, 0, d, n);
    chk("R5 no allocate read misses", n, 1); chk("R5 data from memory", d, 32'h5555_0001);
    cfg_wralloc = 1;
    access(1, 32'h0C4, 3'd1, 32'h5555_0002, d, n);
    access(0, 32'h0C4, 3'd1, 0, d, n);
    chk("R5 allocate read hits", n, 0); chk("R5 allocated data", d, 32'h5555_0002);
    cfg_wralloc = 0;
  endtask

  task automatic test_space();
    logic [31:0] d; int n;
    access(0, 32'h200, 3'd1, 0, d, n);
    access(1, 32'h200, 3'd2, 32'h7777_7777, d, n);
    chk("R6 other-space write out", n, 1);
    access(0, 32'h200, 3'd1, 0, d, n);
    chk("R6 original entry hits", n, 0); chk("R6 original entry untouched", d, init_val(128));
    access(0, 32'h200, 3'd2, 0, d, n);
    chk("R6 other space misses", n, 1); chk("R6 other space data", d, 32'h7777_7777);
  endtask

  task automatic test_bypass();
    logic [31:0] d; int n;
    access(0, 32'h300, 3'd7, 0, d, n);
    access(0, 32'h300, 3'd7, 0, d, n);
    chk("R7 bypass second read to memory", n, 1); chk("R7 bypass data", d, init_val(192));
  endtask

  task automatic test_freeze();
    logic [31:0] d; int n;
    pulse_all();
    access(0, 32'h500, 3'd1, 0, d, n);
    cfg_freeze = 1;
    access(0, 32'h600, 3'd1, 0, d, n);
    access(0, 32'h600, 3'd1, 0, d, n);
    chk("R8 frozen miss not filled", n, 1);
    access(0, 32'h500, 3'd1, 0, d, n);
    chk("R8 entry not replaced", n, 0); chk("R8 entry data", d, init_val(320));
    cfg_wralloc = 1;
    access(1, 32'h704, 3'd1, 32'h8888_0000, d, n);
    access(0, 32'h704, 3'd1, 0, d, n);
    chk("R8 frozen write miss not allocated", n, 1);
    cfg_wralloc = 0; cfg_freeze = 0;
  endtask

  task automatic test_disable();
    logic [31:0] d; int n;
    access(0, 32'h044, 3'd1, 0, d, n);
    cfg_enable = 0;
    access(0, 32'h044, 3'd1, 0, d, n);
    chk("R9 disabled read to memory", n, 1);
    access(1, 32'h044, 3'd1, 32'h9999_0000, d, n);
    chk("R9 disabled write to memory", n, 1);
    cfg_enable = 1;
    access(0, 32'h044, 3'd1, 0, d, n);
    chk("R9 old entry hits", n, 0); chk("R9 old data kept", d, init_val(17));
  endtask

  task automatic test_clear_all();
    logic [31:0] d; int n;
    access(0, 32'h048, 3'd1, 0, d, n);
    pulse_all();
    access(0, 32'h048, 3'd1, 0, d, n);
    chk("R10 cleared misses", n, 1);
  endtask

  task automatic test_clear_one();
    logic [31:0] d; int n;
    access(0, 32'h090, 3'd1, 0, d, n);
    access(0, 32'h094, 3'd1, 0, d, n);
    @(negedge clk); inv_addr = 32'h090; inv_one = 1; @(negedge clk); inv_one = 0;
    access(0, 32'h094, 3'd1, 0, d, n);
    chk("R11 neighbour still hits", n, 0);
    access(0, 32'h090, 3'd1, 0, d, n);
    chk("R11 cleared longword misses", n, 1);
  endtask

  task automatic test_new_tag();
    logic [31:0] d; int n;
    access(0, 32'h0A0, 3'd1, 0, d, n);
    access(0, 32'h0A4, 3'd1, 0, d, n);
    access(0, 32'h4A8, 3'd1, 0, d, n);
    access(0, 32'h4A4, 3'd1, 0, d, n);
    chk("R12 other longwords invalid", n, 1); chk("R12 data from memory", d, init_val(297));
    access(0, 32'h0A0, 3'd1, 0, d, n);
    chk("R1 evicted by conflict", n, 1);
    access(0, 32'h010, 3'd1, 0, d, n);
    access(0, 32'h014, 3'd1, 0, d, n);
    access(0, 32'h010, 3'd1, 0, d, n);
    chk("R1 same line different word no conflict", n, 0);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem_m[i] = init_val(i);
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1;
    cfg_enable = 1;
    test_read_fill();
    test_write_hit();
    test_write_alloc();
    test_space();
    test_bypass();
    test_freeze();
    test_disable();
    test_clear_all();
    test_clear_one();
    test_new_tag();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule